// File: doc/BRIEF.md
# Adaptive ECC Codeword Size Controller

This control unit chooses the codeword length that one flash channel's error-correction engine uses for each new encode or decode. It starts at the smallest codeword, 512 bytes. As the channel wears, it moves up through doubling sizes: 1 KB, 2 KB and so on, up to 32 KB. A longer codeword tolerates a higher raw bit error rate for the same reliability after correction.

The unit watches one of two wear indicators, chosen by a mode input. The first is the number of corrected errors that the decoder reports within one codeword. The second is a running count of write/erase cycles. Each size level has its own programmable threshold, which stands in for the target error rate after correction. When the watched value exceeds the threshold for the current level, the unit requests the next larger size. The change is applied only at a codeword boundary. Once the largest size is in use, a further crossing raises a sticky end-of-life flag.

The outputs are a size code and the parity length that goes with it. The parity budget is 104 bits for every 512-byte unit of codeword. A one-cycle strobe marks each change of size.

Top module: `cw_size_ctrl`

## Requirements
- R1: After reset, the size code is 0 (512 B), the parity length is 104, and both the change strobe and the end-of-life flag are low.
- R2: The size code runs from 0 (512 B) to 6 (32 KB), and each step doubles the size. The parity length always equals 104 × 2^code, which is 104, 208, 416, 832, 1664, 3328 or 6656.
- R3: In error mode (mode input 0), every error report within a codeword is added up. This includes a report given in the same cycle as the codeword-done pulse. The level rises at that done pulse only if the sum is strictly greater than the current level's threshold. A sum equal to the threshold causes no change.
- R4: The error sum is cleared at every codeword-done pulse, and therefore also at every level change. Errors never carry from one codeword into the next.
- R5: In wear mode (mode input 1), a cycle count strictly greater than the current level's threshold raises a request. The request is held, and the level changes only at the next codeword-done pulse.
- R6: In wear mode, error reports have no effect. In error mode, the cycle count triggers nothing, although increments are still counted.
- R7: The change strobe is high for exactly the one cycle after each level increase, and is low at all other times.
- R8: The level never decreases except on reset, and it never goes past 6. A crossing at level 6 sets the end-of-life flag, which then stays high until reset while the size stays at 6.
- R9: Thresholds reset to all ones, so no crossing occurs until one is programmed. A write with a given level index replaces that level's threshold, and later comparisons at that level use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| metric_sel | input | 1 | Wear indicator in use: 0 = corrected errors, 1 = write/erase cycles |
| err_valid | input | 1 | The decoder error report is valid this cycle |
| err_count | input | 8 | Number of corrected errors in this report |
| cw_done | input | 1 | Pulse at the end of the current codeword |
| cyc_inc | input | 1 | One more write/erase cycle has completed |
| thr_wr | input | 1 | Write strobe for a threshold |
| thr_idx | input | 3 | Level index of the threshold to write |
| thr_val | input | 20 | Threshold value to write |
| size_code | output | 3 | Current codeword size code |
| parity_bits | output | 13 | Parity bit count for the current size |
| size_valid | output | 1 | One-cycle strobe after each size change |
| eol | output | 1 | Sticky end-of-life flag |

## Verification
In error mode, the tests use split reports that sum to exactly the threshold and to one above it. This separates a strict comparison from an inclusive one and shows that reports within one codeword are added together. Repeated codewords that each stay just under the threshold show whether the sum is cleared at each boundary. Crossings in wear mode are held over several idle cycles before any done pulse arrives, which shows that a change waits for the boundary. Each mode is also driven with the other mode's indicator to show that it is ignored. Finally, the level is stepped all the way to the top size and past it, which checks every parity value, the saturation at level 6, the sticky end-of-life flag and the thresholds' reset value.

// File: rtl/cwsz_pkg.sv
package cwsz_pkg;
  localparam int unsigned CW_LEVELS_DEF = 7;
  localparam int unsigned PAR_UNIT_DEF  = 104;
  typedef enum logic {METRIC_ERR = 1'b0, METRIC_WEAR = 1'b1} metric_e;
endpackage

// File: rtl/cwsz_thr_bank.sv
module cwsz_thr_bank #(
  parameter int unsigned LEVELS = 7,
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned THR_W  = 20,
  parameter logic [THR_W-1:0] THR_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LVL_W-1:0] wr_idx,
  input  logic [THR_W-1:0] wr_data,
  input  logic [LVL_W-1:0] lvl,
  output logic [THR_W-1:0] thr_sel
);
  logic [THR_W-1:0] thr_q [LEVELS];
  logic [THR_W-1:0] thr_d [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == LVL_W'(g));

    always_comb begin
      thr_d[g] = thr_q[g];
      if (hit) thr_d[g] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) thr_q[g] <= THR_RST;
      else if (hit) thr_q[g] <= thr_d[g];
    end
  end

  always_comb begin
    thr_sel = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (lvl == LVL_W'(i)) thr_sel = thr_q[i];
    end
  end
endmodule

// File: rtl/cwsz_monitor.sv
module cwsz_monitor
  import cwsz_pkg::*;
#(
  parameter int unsigned ERR_W = 8,
  parameter int unsigned THR_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  metric_e          metric,
  input  logic             err_valid,
  input  logic [ERR_W-1:0] err_count,
  input  logic             cyc_inc,
  input  logic             cw_done,
  input  logic [THR_W-1:0] thr_sel,
  output logic             req
);
  logic [THR_W-1:0] err_acc_q, err_acc_d;
  logic [THR_W-1:0] cyc_cnt_q, cyc_cnt_d;
  logic             pend_q, pend_d;
  logic [THR_W:0]   err_sum;
  logic [THR_W-1:0] err_stat;
  logic             err_cross, wear_cross;

  // running error total for this codeword, saturating
  always_comb begin
    err_sum  = {1'b0, err_acc_q} + (err_valid ? (THR_W+1)'(err_count) : '0);
    err_stat = err_sum[THR_W] ? '1 : err_sum[THR_W-1:0];
  end

  assign err_cross  = (metric == METRIC_ERR) && cw_done && (err_stat > thr_sel);
  assign wear_cross = (metric == METRIC_WEAR) && (cyc_cnt_q > thr_sel);
  assign req        = err_cross || wear_cross || pend_q;

  always_comb begin
    err_acc_d = cw_done ? '0 : err_stat;
    cyc_cnt_d = cyc_cnt_q;
    if (cyc_inc && (cyc_cnt_q != '1)) cyc_cnt_d = cyc_cnt_q + 1'b1;
    pend_d = pend_q;
    if (cw_done)         pend_d = 1'b0;
    else if (wear_cross) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_acc_q <= '0;
      cyc_cnt_q <= '0;
      pend_q    <= 1'b0;
    end else begin
      err_acc_q <= err_acc_d;
      cyc_cnt_q <= cyc_cnt_d;
      pend_q    <= pend_d;
    end
  end

  // R4: nothing carries past a codeword boundary
  assert_acc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cw_done |=> (err_acc_q == '0));
  // R6: the cycle count only moves on an increment
  assert_cyc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_inc |=> $stable(cyc_cnt_q));
  // R5: a held wear request survives until the boundary
  assert_pend_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !cw_done) |=> pend_q);
endmodule

// File: rtl/cwsz_level_fsm.sv
module cwsz_level_fsm #(
  parameter int unsigned LEVELS = 7,
  parameter int unsigned LVL_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cw_done,
  input  logic             req,
  output logic [LVL_W-1:0] lvl,
  output logic             size_valid,
  output logic             eol
);
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(LEVELS - 1);

  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             strobe_q, strobe_d;
  logic             eol_q, eol_d;
  logic             adv, at_max;

  assign adv    = cw_done && req;
  assign at_max = (lvl_q == LVL_MAX);

  always_comb begin
    lvl_d    = lvl_q;
    strobe_d = 1'b0;
    eol_d    = eol_q;
    if (adv) begin
      if (at_max) begin
        eol_d = 1'b1;
      end else begin
        lvl_d    = lvl_q + 1'b1;
        strobe_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= '0;
      strobe_q <= 1'b0;
      eol_q    <= 1'b0;
    end else begin
      lvl_q    <= lvl_d;
      strobe_q <= strobe_d;
      eol_q    <= eol_d;
    end
  end

  assign lvl        = lvl_q;
  assign size_valid = strobe_q;
  assign eol        = eol_q;

  assert_no_decrease_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lvl_q >= $past(lvl_q)));
  assert_level_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_MAX);
  assert_eol_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eol_q |=> eol_q);
  assert_boundary_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cw_done |=> $stable(lvl_q));
  assert_strobe_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> (lvl_q == $past(lvl_q) + 1'b1));
endmodule

// File: rtl/cwsz_parity.sv
module cwsz_parity #(
  parameter int unsigned LEVELS   = 7,
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned PAR_UNIT = 104,
  parameter int unsigned PAR_W    = 13
) (
  input  logic [LVL_W-1:0] lvl,
  output logic [PAR_W-1:0] parity
);
  logic [PAR_W-1:0] tbl [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_tbl
    assign tbl[g] = PAR_W'(PAR_UNIT << g);
  end

  always_comb begin
    parity = tbl[0];
    for (int i = 0; i < LEVELS; i++) begin
      if (lvl == LVL_W'(i)) parity = tbl[i];
    end
  end
endmodule

// File: rtl/cw_size_ctrl.sv
module cw_size_ctrl
  import cwsz_pkg::*;
#(
  parameter int unsigned LEVELS   = CW_LEVELS_DEF,
  parameter int unsigned ERR_W    = 8,
  parameter int unsigned THR_W    = 20,
  parameter int unsigned PAR_UNIT = PAR_UNIT_DEF,
  parameter logic [THR_W-1:0] THR_RST = '1,
  localparam int unsigned LVL_W = $clog2(LEVELS),
  localparam int unsigned PAR_W = $clog2(PAR_UNIT * (1 << (LEVELS - 1)) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             metric_sel,
  input  logic             err_valid,
  input  logic [ERR_W-1:0] err_count,
  input  logic             cw_done,
  input  logic             cyc_inc,
  input  logic             thr_wr,
  input  logic [LVL_W-1:0] thr_idx,
  input  logic [THR_W-1:0] thr_val,
  output logic [LVL_W-1:0] size_code,
  output logic [PAR_W-1:0] parity_bits,
  output logic             size_valid,
  output logic             eol
);
  logic [THR_W-1:0] thr_sel;
  logic             req;
  logic [LVL_W-1:0] lvl;
  metric_e          metric;

  assign metric = metric_e'(metric_sel);

  cwsz_thr_bank #(.LEVELS(LEVELS), .LVL_W(LVL_W), .THR_W(THR_W), .THR_RST(THR_RST)) i_thr (
    .clk(clk), .rst_n(rst_n), .wr_en(thr_wr), .wr_idx(thr_idx), .wr_data(thr_val),
    .lvl(lvl), .thr_sel(thr_sel));

  cwsz_monitor #(.ERR_W(ERR_W), .THR_W(THR_W)) i_mon (
    .clk(clk), .rst_n(rst_n), .metric(metric), .err_valid(err_valid),
    .err_count(err_count), .cyc_inc(cyc_inc), .cw_done(cw_done),
    .thr_sel(thr_sel), .req(req));

  cwsz_level_fsm #(.LEVELS(LEVELS), .LVL_W(LVL_W)) i_fsm (
    .clk(clk), .rst_n(rst_n), .cw_done(cw_done), .req(req),
    .lvl(lvl), .size_valid(size_valid), .eol(eol));

  cwsz_parity #(.LEVELS(LEVELS), .LVL_W(LVL_W), .PAR_UNIT(PAR_UNIT), .PAR_W(PAR_W)) i_par (
    .lvl(lvl), .parity(parity_bits));

  assign size_code = lvl;

  // R2: parity is a power-of-two multiple of the per-unit budget
  assert_parity_scale_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((parity_bits % PAR_W'(PAR_UNIT)) == '0) && ($countones(parity_bits / PAR_W'(PAR_UNIT)) == 1));
endmodule

// File: tb/test_cw_size_ctrl.sv
module test_cw_size_ctrl;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        metric_sel, err_valid, cw_done, cyc_inc, thr_wr;
  logic [7:0]  err_count;
  logic [2:0]  thr_idx;
  logic [19:0] thr_val;
  logic [2:0]  size_code;
  logic [12:0] parity_bits;
  logic        size_valid, eol;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  cw_size_ctrl i_cw_size_ctrl (
    .clk(clk), .rst_n(rst_n), .metric_sel(metric_sel), .err_valid(err_valid),
    .err_count(err_count), .cw_done(cw_done), .cyc_inc(cyc_inc), .thr_wr(thr_wr),
    .thr_idx(thr_idx), .thr_val(thr_val), .size_code(size_code),
    .parity_bits(parity_bits), .size_valid(size_valid), .eol(eol));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(bit ev, int ec, bit done, bit inc);
    err_valid = ev; err_count = 8'(ec); cw_done = done; cyc_inc = inc;
    @(negedge clk);
    err_valid = 0; err_count = '0; cw_done = 0; cyc_inc = 0;
  endtask

  task automatic wr_thr(int idx, int val);
    thr_wr = 1; thr_idx = 3'(idx); thr_val = 20'(val);
    @(negedge clk);
    thr_wr = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    metric_sel = 0; err_valid = 0; err_count = '0; cw_done = 0; cyc_inc = 0;
    thr_wr = 0; thr_idx = '0; thr_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "size_code", size_code, 0);
    chk("R1", "parity", parity_bits, 104);
    chk("R1", "size_valid", size_valid, 0);
    chk("R1", "eol", eol, 0);
  endtask

  task automatic t_error_mode();
    wr_thr(0, 10); wr_thr(1, 10);
    metric_sel = 0;
    drive(1, 4, 0, 0); drive(1, 6, 1, 0);          // sum 10 == thr
    chk("R3", "equal sum no step", size_code, 0);
    chk("R7", "no strobe without step", size_valid, 0);
    drive(1, 5, 0, 0); drive(1, 6, 1, 0);          // sum 11 > thr
    chk("R3", "over sum steps", size_code, 1);
    chk("R7", "strobe after step", size_valid, 1);
    chk("R2", "parity level 1", parity_bits, 208);
    @(negedge clk);
    chk("R7", "strobe one cycle", size_valid, 0);
    drive(1, 9, 1, 0); drive(1, 9, 1, 0);          // 9 per codeword
    chk("R4", "no carry across codewords", size_code, 1);
  endtask

  task automatic t_metric_ignore();
    metric_sel = 0;
    for (int i = 0; i < 12; i++) drive(0, 0, 0, 1); // cycle count 12 > 10
    drive(0, 0, 1, 0);
    chk("R6", "cycle count ignored in error mode", size_code, 1);
  endtask

  task automatic t_wear_mode();
    wr_thr(2, 20);
    metric_sel = 1;
    repeat (5) @(negedge clk);
    chk("R5", "held until boundary", size_code, 1);
    drive(0, 0, 1, 0);
    chk("R5", "step at boundary", size_code, 2);
    chk("R2", "parity level 2", parity_bits, 416);
    drive(1, 200, 1, 0);
    chk("R6", "errors ignored in wear mode", size_code, 2);
    for (int i = 0; i < 9; i++) drive(0, 0, 0, 1); // count 21 > 20
    @(negedge clk);
    chk("R5", "no step without boundary", size_code, 2);
    drive(0, 0, 1, 0);
    chk("R5", "wear step to 3", size_code, 3);
    chk("R2", "parity level 3", parity_bits, 832);
  endtask

  task automatic t_top_level();
    for (int l = 3; l < 7; l++) wr_thr(l, 0);
    drive(0, 0, 1, 0);
    chk("R2", "parity level 4", parity_bits, 1664);
    drive(0, 0, 1, 0);
    chk("R2", "parity level 5", parity_bits, 3328);
    drive(0, 0, 1, 0);
    chk("R2", "code level 6", size_code, 6);
    chk("R2", "parity level 6", parity_bits, 6656);
    chk("R8", "eol low before crossing at top", eol, 0);
    drive(0, 0, 1, 0);
    chk("R8", "saturate at 6", size_code, 6);
    chk("R8", "eol set", eol, 1);
    chk("R7", "no strobe at top", size_valid, 0);
    drive(0, 0, 1, 0);
    repeat (3) @(negedge clk);
    chk("R8", "eol sticky", eol, 1);
    chk("R8", "still 6", size_code, 6);
  endtask

  task automatic t_threshold_reset();
    do_reset();
    chk("R1", "code back to 0", size_code, 0);
    chk("R1", "eol cleared", eol, 0);
    metric_sel = 0;
    drive(1, 255, 1, 0);
    chk("R9", "reset threshold all ones", size_code, 0);
    wr_thr(0, 100);
    drive(1, 101, 1, 0);
    chk("R9", "programmed threshold used", size_code, 1);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_error_mode();
    t_metric_ignore();
    t_wear_mode();
    t_top_level();
    t_threshold_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule